// File: doc/BRIEF.md
# Floating-Point Scoreboard Issue Controller

This block is the control core of a centrally scoreboarded floating-point pipeline. It takes decoded instructions one per cycle: an operation code, a destination register and two source registers. It sends each one to a functional unit. Instructions issue strictly in program order, and they may finish out of order. The block models no arithmetic and carries no data. Each unit is a countdown of its latency, and the block only decides when each instruction may move from issue to operand read, then to execution complete, then to result write.

Three tables hold the state, and all of them are visible at the ports. The unit table has one row per functional unit. A row holds a busy flag, the operation, the destination and source register numbers, the producing unit of each source, and a ready flag for each source. The register result table gives, for each floating-point register, the unit that will write it next. The instruction status table is read through a select port by sequence number. For each instruction it gives the current stage and the cycle stamp of every stage reached. This lets a caller inspect the complete scoreboard at the moment any instruction writes its result.

There are five units: a load unit, two multipliers, one adder that serves both add and subtract, and a divider. The `stall` output tells the instruction source to hold its current instruction.

Top module: `fp_scoreboard`

## Requirements
- R1: After reset, every unit is free, every register result entry is 0, `stall` is low while `instValid` is low, and every status entry reads stage 0.
- R2: Unit and latency by operation code: 0 = load → load unit (index 0), 1 cycle; 1 = add and 2 = subtract → adder (index 3), 2 cycles; 3 = multiply → multiplier index 1, or index 2 if index 1 is busy, 10 cycles; 4 = divide → divider (index 4), 40 cycles. Execute-complete stamp minus operand-read stamp equals the latency.
- R3: An instruction whose unit (or, for multiply, both multipliers) is busy raises `stall` and is not issued. It issues in the cycle after the blocking unit writes its result, and no later instruction issues ahead of it.
- R4: An instruction whose destination already has a pending writer in the register result table stalls. It issues in the cycle after that writer writes.
- R5: Each stage takes at least one cycle: operand read is stamped at least one cycle after issue, and result write at least one cycle after execute completion.
- R6: A source produced by a pending unit is read in the cycle after that unit writes its result. Once operands are read, both ready flags of the unit are cleared.
- R7: A unit that has finished executing does not write while another busy floating-point unit still has a ready, unread source naming its destination. It writes in the cycle after that reader reads.
- R8: On issue, the unit row records the operation and the register numbers. A source with a pending producer gets producer code = unit index + 1 and ready = 0. A source with no pending producer gets code 0 and ready = 1. The destination's register result entry becomes unit index + 1. A load takes no floating-point sources: both of its ready flags are set at issue.
- R9: Status entry `seq mod 16` (seq counts accepted instructions from 0 after reset) gives the stage (1 issued, 2 operands read, 3 execute complete, 4 written) and the four cycle stamps.
- R10: `writeStrobe[u]` is high in the cycle unit u writes its result. At the following edge the unit becomes free and its destination's register result entry returns to 0. Two units may write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction present |
| instOp | input | 3 | Operation code (see R2) |
| instDst | input | 5 | Destination register |
| instSrc1 | input | 5 | First source register (base integer register for a load) |
| instSrc2 | input | 5 | Second source register |
| stall | output | 1 | Current instruction cannot issue this cycle |
| writeStrobe | output | 5 | Per-unit result write in this cycle |
| fuBusy | output | 5 | Unit busy flags |
| fuOpTab | output | 15 | Operation per unit, 3 bits each |
| fuFiTab | output | 25 | Destination register per unit |
| fuFjTab | output | 25 | First source register per unit |
| fuFkTab | output | 25 | Second source register per unit |
| fuQjTab | output | 15 | First source producer code per unit |
| fuQkTab | output | 15 | Second source producer code per unit |
| fuRjTab | output | 5 | First source ready per unit |
| fuRkTab | output | 5 | Second source ready per unit |
| regResultTab | output | 96 | Pending writer code per register, 3 bits each |
| statSel | input | 4 | Status table entry select |
| statStage | output | 3 | Stage of selected entry |
| statIssue | output | 16 | Issue cycle stamp |
| statRead | output | 16 | Operand read cycle stamp |
| statExec | output | 16 | Execute complete cycle stamp |
| statWrite | output | 16 | Result write cycle stamp |

## Verification
The hardest state to reach from the ports is a result write held back by a slow reader. In that state a short multiply has finished, but it must wait because an add that names the multiply's destination as a source is itself waiting on a forty-cycle divide. The stimulus builds this with a divide, a dependent add and a multiply, issued back to back. A load to the divide's destination follows them, so the same run also exercises the pending-writer stall, and the load's result write falls in the same cycle as the add's. The stimulus then shows the structural stalls with three multiplies in a row.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;
  localparam int CODE_W = 3;

  localparam int unsigned U_LOAD = 0;
  localparam int unsigned U_MULA = 1;
  localparam int unsigned U_MULB = 2;
  localparam int unsigned U_ADD  = 3;
  localparam int unsigned U_DIV  = 4;

  typedef enum logic [2:0] {
    OP_LD    = 3'd0,
    OP_ADDD  = 3'd1,
    OP_SUBD  = 3'd2,
    OP_MULTD = 3'd3,
    OP_DIVD  = 3'd4
  } fpOp_e;

  typedef struct packed {
    logic              issue;
    logic [2:0]        issueUnit;
    logic [NUM_FU-1:0] readMask;
    logic [NUM_FU-1:0] doneMask;
    logic [NUM_FU-1:0] writeMask;
  } sbStrobe_t;

  function automatic int unsigned unitLat(input int unsigned u, input int unsigned ldLat,
                                          input int unsigned addLat, input int unsigned mulLat,
                                          input int unsigned divLat);
    case (u)
      U_LOAD:         return ldLat;
      U_MULA, U_MULB: return mulLat;
      U_ADD:          return addLat;
      default:        return divLat;
    endcase
  endfunction
endpackage

// File: rtl/sb_unit_timer.sv
module sb_unit_timer #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic opsReady,
  input  logic warFree,
  output logic readFire,
  output logic doneFire,
  output logic writeFire
);
  localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1);

  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_EXEC, T_DONE} tState_e;
  tState_e st;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    readFire  = (st == T_WAIT) && opsReady;
    doneFire  = (st == T_EXEC) && (cnt == CNT_W'(1));
    writeFire = (st == T_DONE) && warFree;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= T_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        T_IDLE: if (start) st <= T_WAIT;
        T_WAIT: if (readFire) begin
          st  <= T_EXEC;
          cnt <= CNT_W'(LAT);
        end
        T_EXEC: if (cnt == CNT_W'(1)) st <= T_DONE;
                else cnt <= cnt - CNT_W'(1);
        default: if (warFree) st <= T_IDLE;
      endcase
    end
  end

  // R3: control must only start a unit that is idle
  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (st == T_IDLE));
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REG = 32,
  parameter int REG_W   = 5,
  parameter int unsigned LAT_LD  = 1,
  parameter int unsigned LAT_ADD = 2,
  parameter int unsigned LAT_MUL = 10,
  parameter int unsigned LAT_DIV = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic instValid,
  input  logic [2:0] instOp,
  input  logic [REG_W-1:0] instDst,
  input  logic [NUM_FU-1:0] fuBusy,
  input  logic [NUM_FU-1:0] fuRj,
  input  logic [NUM_FU-1:0] fuRk,
  input  logic [NUM_FU-1:0] fuFpSrc,
  input  logic [NUM_FU-1:0][REG_W-1:0] fuFi,
  input  logic [NUM_FU-1:0][REG_W-1:0] fuFj,
  input  logic [NUM_FU-1:0][REG_W-1:0] fuFk,
  input  logic [NUM_REG-1:0][CODE_W-1:0] regResult,
  output sbStrobe_t strb,
  output logic stall
);
  logic unitFree;
  logic [2:0] pickUnit;
  logic wawHit;
  logic [NUM_FU-1:0] warFree;
  logic [NUM_FU-1:0] opsReady;
  logic [NUM_FU-1:0] startVec;
  logic [NUM_FU-1:0] readVec, doneVec, writeVec;

  always_comb begin
    unitFree = 1'b0;
    pickUnit = 3'(U_LOAD);
    case (instOp)
      OP_LD: begin
        pickUnit = 3'(U_LOAD);
        unitFree = !fuBusy[U_LOAD];
      end
      OP_ADDD, OP_SUBD: begin
        pickUnit = 3'(U_ADD);
        unitFree = !fuBusy[U_ADD];
      end
      OP_MULTD: begin
        if (!fuBusy[U_MULA]) begin
          pickUnit = 3'(U_MULA);
          unitFree = 1'b1;
        end else begin
          pickUnit = 3'(U_MULB);
          unitFree = !fuBusy[U_MULB];
        end
      end
      OP_DIVD: begin
        pickUnit = 3'(U_DIV);
        unitFree = !fuBusy[U_DIV];
      end
      default: begin
        pickUnit = 3'(U_LOAD);
        unitFree = 1'b0;
      end
    endcase
  end

  assign wawHit = (regResult[instDst] != '0);
  assign stall  = instValid && (!unitFree || wawHit);

  // WAR: a finished unit waits while some other unit still has to read its destination
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      warFree[u] = 1'b1;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && fuBusy[v] && fuFpSrc[v] &&
            ((fuRj[v] && fuFj[v] == fuFi[u]) || (fuRk[v] && fuFk[v] == fuFi[u])))
          warFree[u] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      opsReady[u] = fuBusy[u] && fuRj[u] && fuRk[u];
      startVec[u] = instValid && !stall && (pickUnit == 3'(u));
    end
  end

  for (genvar g = 0; g < NUM_FU; g++) begin : g_timer
    localparam int unsigned L = unitLat(g, LAT_LD, LAT_ADD, LAT_MUL, LAT_DIV);
    sb_unit_timer #(.LAT(L)) i_timer (
      .clk(clk),
      .rstN(rstN),
      .start(startVec[g]),
      .opsReady(opsReady[g]),
      .warFree(warFree[g]),
      .readFire(readVec[g]),
      .doneFire(doneVec[g]),
      .writeFire(writeVec[g])
    );
  end

  always_comb begin
    strb.issue     = instValid && !stall;
    strb.issueUnit = pickUnit;
    strb.readMask  = readVec;
    strb.doneMask  = doneVec;
    strb.writeMask = writeVec;
  end
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int NUM_REG    = 32,
  parameter int REG_W      = 5,
  parameter int CYC_W      = 16,
  parameter int STAT_DEPTH = 16,
  parameter int IDX_W      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  sbStrobe_t strb,
  input  logic [2:0] instOp,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrc1,
  input  logic [REG_W-1:0] instSrc2,
  input  logic [IDX_W-1:0] statSel,
  output logic [NUM_FU-1:0] fuBusy,
  output logic [NUM_FU-1:0][2:0] fuOp,
  output logic [NUM_FU-1:0][REG_W-1:0] fuFi,
  output logic [NUM_FU-1:0][REG_W-1:0] fuFj,
  output logic [NUM_FU-1:0][REG_W-1:0] fuFk,
  output logic [NUM_FU-1:0][CODE_W-1:0] fuQj,
  output logic [NUM_FU-1:0][CODE_W-1:0] fuQk,
  output logic [NUM_FU-1:0] fuRj,
  output logic [NUM_FU-1:0] fuRk,
  output logic [NUM_FU-1:0] fuFpSrc,
  output logic [NUM_REG-1:0][CODE_W-1:0] regResult,
  output logic [2:0] statStage,
  output logic [CYC_W-1:0] statIssue,
  output logic [CYC_W-1:0] statRead,
  output logic [CYC_W-1:0] statExec,
  output logic [CYC_W-1:0] statWrite
);
  logic [CYC_W-1:0] cycleCnt;
  logic [IDX_W-1:0] issueSeq;
  logic [NUM_FU-1:0][IDX_W-1:0] fuSeq;
  logic [2:0]       stStage [STAT_DEPTH];
  logic [CYC_W-1:0] stIssue [STAT_DEPTH];
  logic [CYC_W-1:0] stRead  [STAT_DEPTH];
  logic [CYC_W-1:0] stExec  [STAT_DEPTH];
  logic [CYC_W-1:0] stWrite [STAT_DEPTH];

  logic [CODE_W-1:0] prodJ, prodK;
  logic readyJ, readyK, isLoad;

  // A producer writing in this very cycle counts as already resolved
  function automatic logic writtenNow(input logic [CODE_W-1:0] code,
                                      input logic [NUM_FU-1:0] wm);
    if (code == '0) return 1'b1;
    for (int i = 0; i < NUM_FU; i++)
      if (code == CODE_W'(i + 1) && wm[i]) return 1'b1;
    return 1'b0;
  endfunction

  always_comb begin
    isLoad = (instOp == OP_LD);
    prodJ  = regResult[instSrc1];
    prodK  = regResult[instSrc2];
    readyJ = isLoad || writtenNow(prodJ, strb.writeMask);
    readyK = isLoad || writtenNow(prodK, strb.writeMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt  <= '0;
      issueSeq  <= '0;
      fuBusy    <= '0;
      fuOp      <= '0;
      fuFi      <= '0;
      fuFj      <= '0;
      fuFk      <= '0;
      fuQj      <= '0;
      fuQk      <= '0;
      fuRj      <= '0;
      fuRk      <= '0;
      fuFpSrc   <= '0;
      fuSeq     <= '0;
      regResult <= '0;
      for (int i = 0; i < STAT_DEPTH; i++) begin
        stStage[i] <= '0;
        stIssue[i] <= '0;
        stRead[i]  <= '0;
        stExec[i]  <= '0;
        stWrite[i] <= '0;
      end
    end else begin
      cycleCnt <= cycleCnt + CYC_W'(1);
      for (int u = 0; u < NUM_FU; u++) begin
        if (strb.writeMask[u]) begin
          fuBusy[u]  <= 1'b0;
          fuOp[u]    <= '0;
          fuFi[u]    <= '0;
          fuFj[u]    <= '0;
          fuFk[u]    <= '0;
          fuQj[u]    <= '0;
          fuQk[u]    <= '0;
          fuRj[u]    <= 1'b0;
          fuRk[u]    <= 1'b0;
          fuFpSrc[u] <= 1'b0;
          regResult[fuFi[u]] <= '0;
          stStage[fuSeq[u]]  <= 3'd4;
          stWrite[fuSeq[u]]  <= cycleCnt;
          for (int v = 0; v < NUM_FU; v++) begin
            if (fuQj[v] == CODE_W'(u + 1)) begin
              fuQj[v] <= '0;
              fuRj[v] <= 1'b1;
            end
            if (fuQk[v] == CODE_W'(u + 1)) begin
              fuQk[v] <= '0;
              fuRk[v] <= 1'b1;
            end
          end
        end
        if (strb.readMask[u]) begin
          fuRj[u] <= 1'b0;
          fuRk[u] <= 1'b0;
          stStage[fuSeq[u]] <= 3'd2;
          stRead[fuSeq[u]]  <= cycleCnt;
        end
        if (strb.doneMask[u]) begin
          stStage[fuSeq[u]] <= 3'd3;
          stExec[fuSeq[u]]  <= cycleCnt;
        end
      end
      if (strb.issue) begin
        fuBusy[strb.issueUnit]  <= 1'b1;
        fuOp[strb.issueUnit]    <= instOp;
        fuFi[strb.issueUnit]    <= instDst;
        fuFj[strb.issueUnit]    <= instSrc1;
        fuFk[strb.issueUnit]    <= isLoad ? '0 : instSrc2;
        fuQj[strb.issueUnit]    <= readyJ ? '0 : prodJ;
        fuQk[strb.issueUnit]    <= readyK ? '0 : prodK;
        fuRj[strb.issueUnit]    <= readyJ;
        fuRk[strb.issueUnit]    <= readyK;
        fuFpSrc[strb.issueUnit] <= !isLoad;
        fuSeq[strb.issueUnit]   <= issueSeq;
        regResult[instDst]      <= CODE_W'(strb.issueUnit) + CODE_W'(1);
        stStage[issueSeq]       <= 3'd1;
        stIssue[issueSeq]       <= cycleCnt;
        stRead[issueSeq]        <= '0;
        stExec[issueSeq]        <= '0;
        stWrite[issueSeq]       <= '0;
        issueSeq                <= issueSeq + IDX_W'(1);
      end
    end
  end

  always_comb begin
    statStage = stStage[statSel];
    statIssue = stIssue[statSel];
    statRead  = stRead[statSel];
    statExec  = stExec[statSel];
    statWrite = stWrite[statSel];
  end

  // R3: the control never issues into an occupied unit
  p_issue_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> !fuBusy[strb.issueUnit]);

  // R4: the control never issues over a pending writer of the same register
  p_waw_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (regResult[instDst] == '0));

  for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
    // R6: operands are read only once both ready flags are set
    p_read_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.readMask[g] |-> (fuRj[g] && fuRk[g]));
    // R6: reading clears the ready flags
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.readMask[g] |=> (!fuRj[g] && !fuRk[g]));
    // R10: a write frees the unit at the next edge
    p_write_frees_r10: assert property (@(posedge clk) disable iff (!rstN)
      strb.writeMask[g] |=> !fuBusy[g]);
  end
endmodule

// File: rtl/fp_scoreboard.sv
module fp_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REG    = 32,
  parameter int CYC_W      = 16,
  parameter int STAT_DEPTH = 16,
  parameter int unsigned LAT_LD  = 1,
  parameter int unsigned LAT_ADD = 2,
  parameter int unsigned LAT_MUL = 10,
  parameter int unsigned LAT_DIV = 40,
  localparam int REG_W = $clog2(NUM_REG),
  localparam int IDX_W = $clog2(STAT_DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic instValid,
  input  logic [2:0] instOp,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrc1,
  input  logic [REG_W-1:0] instSrc2,
  output logic stall,
  output logic [NUM_FU-1:0] writeStrobe,
  output logic [NUM_FU-1:0] fuBusy,
  output logic [NUM_FU*3-1:0] fuOpTab,
  output logic [NUM_FU*REG_W-1:0] fuFiTab,
  output logic [NUM_FU*REG_W-1:0] fuFjTab,
  output logic [NUM_FU*REG_W-1:0] fuFkTab,
  output logic [NUM_FU*CODE_W-1:0] fuQjTab,
  output logic [NUM_FU*CODE_W-1:0] fuQkTab,
  output logic [NUM_FU-1:0] fuRjTab,
  output logic [NUM_FU-1:0] fuRkTab,
  output logic [NUM_REG*CODE_W-1:0] regResultTab,
  input  logic [IDX_W-1:0] statSel,
  output logic [2:0] statStage,
  output logic [CYC_W-1:0] statIssue,
  output logic [CYC_W-1:0] statRead,
  output logic [CYC_W-1:0] statExec,
  output logic [CYC_W-1:0] statWrite
);
  sbStrobe_t strb;
  logic [NUM_FU-1:0] busyW, rjW, rkW, fpSrcW;
  logic [NUM_FU-1:0][2:0] opW;
  logic [NUM_FU-1:0][REG_W-1:0] fiW, fjW, fkW;
  logic [NUM_FU-1:0][CODE_W-1:0] qjW, qkW;
  logic [NUM_REG-1:0][CODE_W-1:0] resW;

  sb_ctrl #(
    .NUM_REG(NUM_REG), .REG_W(REG_W),
    .LAT_LD(LAT_LD), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .instOp(instOp), .instDst(instDst),
    .fuBusy(busyW), .fuRj(rjW), .fuRk(rkW), .fuFpSrc(fpSrcW),
    .fuFi(fiW), .fuFj(fjW), .fuFk(fkW), .regResult(resW),
    .strb(strb), .stall(stall)
  );

  sb_datapath #(
    .NUM_REG(NUM_REG), .REG_W(REG_W), .CYC_W(CYC_W),
    .STAT_DEPTH(STAT_DEPTH), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .instOp(instOp), .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .statSel(statSel),
    .fuBusy(busyW), .fuOp(opW), .fuFi(fiW), .fuFj(fjW), .fuFk(fkW),
    .fuQj(qjW), .fuQk(qkW), .fuRj(rjW), .fuRk(rkW), .fuFpSrc(fpSrcW),
    .regResult(resW),
    .statStage(statStage), .statIssue(statIssue), .statRead(statRead),
    .statExec(statExec), .statWrite(statWrite)
  );

  assign writeStrobe  = strb.writeMask;
  assign fuBusy       = busyW;
  assign fuOpTab      = opW;
  assign fuFiTab      = fiW;
  assign fuFjTab      = fjW;
  assign fuFkTab      = fkW;
  assign fuQjTab      = qjW;
  assign fuQkTab      = qkW;
  assign fuRjTab      = rjW;
  assign fuRkTab      = rkW;
  assign regResultTab = resW;
endmodule

// File: tb/test_fp_scoreboard.sv
module test_fp_scoreboard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [2:0] instOp = '0;
  logic [4:0] instDst = '0, instSrc1 = '0, instSrc2 = '0;
  logic stall;
  logic [4:0] writeStrobe, fuBusy, fuRjTab, fuRkTab;
  logic [14:0] fuOpTab, fuQjTab, fuQkTab;
  logic [24:0] fuFiTab, fuFjTab, fuFkTab;
  logic [95:0] regResultTab;
  logic [3:0] statSel = '0;
  logic [2:0] statStage;
  logic [15:0] statIssue, statRead, statExec, statWrite;

  int total = 0;
  int bad = 0;
  int seqCnt = 0;
  bit finished = 0;
  int expQ[$];

  always #2 clk = ~clk;

  fp_scoreboard i_fp_scoreboard (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .stall(stall), .writeStrobe(writeStrobe), .fuBusy(fuBusy),
    .fuOpTab(fuOpTab), .fuFiTab(fuFiTab), .fuFjTab(fuFjTab), .fuFkTab(fuFkTab),
    .fuQjTab(fuQjTab), .fuQkTab(fuQkTab), .fuRjTab(fuRjTab), .fuRkTab(fuRkTab),
    .regResultTab(regResultTab), .statSel(statSel), .statStage(statStage),
    .statIssue(statIssue), .statRead(statRead), .statExec(statExec),
    .statWrite(statWrite)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // driver: present one instruction and hold it until accepted
  task automatic issueInst(input logic [2:0] op, input int dst, input int s1, input int s2,
                           output int seq, output int waited);
    @(negedge clk);
    instValid = 1'b1;
    instOp = op;
    instDst = 5'(dst);
    instSrc1 = 5'(s1);
    instSrc2 = 5'(s2);
    waited = 0;
    #1;
    while (stall) begin
      waited++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    seq = seqCnt;
    seqCnt++;
    #1;
    instValid = 1'b0;
  endtask

  task automatic getStat(input int seq, output int stg, output int iss, output int rd,
                         output int ex, output int wr);
    statSel = 4'(seq);
    #1;
    stg = int'(statStage);
    iss = int'(statIssue);
    rd  = int'(statRead);
    ex  = int'(statExec);
    wr  = int'(statWrite);
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (fuBusy != '0 && n < 500) begin
      n++;
      @(negedge clk);
    end
  endtask

  // monitor: compare each result write against the expected order
  always @(negedge clk) begin
    if (rstN && writeStrobe != '0) begin
      for (int u = 0; u < 5; u++) begin
        if (writeStrobe[u]) begin
          if (expQ.size() == 0) chk("R10 unexpected write", u, -1);
          else chk("R10 write order", u, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s[11];
    int w, stg, iss, rd, ex, wr;
    int iss0, rd0, ex0, wr0;
    int wrB, rdB, exB;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 stall", stall, 0);
    chk("R1 busy", fuBusy, 0);
    chk("R1 regResult", (regResultTab == '0), 1);
    getStat(0, stg, iss, rd, ex, wr);
    chk("R1 status stage", stg, 0);

    // Scenario A: RAW chain and structural stall on the adder
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(3); expQ.push_back(3);
    issueInst(3'd0, 0, 2, 0, s[0], w);
    issueInst(3'd3, 6, 0, 2, s[1], w);
    chk("R8 mulA Qj code", fuQjTab[3 +: 3], 1);
    chk("R8 mulA Rj", fuRjTab[1], 0);
    chk("R8 mulA Rk", fuRkTab[1], 1);
    chk("R8 regResult F6", regResultTab[18 +: 3], 2);
    issueInst(3'd1, 8, 6, 0, s[2], w);
    issueInst(3'd2, 10, 2, 2, s[3], w);
    chk("R3 adder stall seen", (w > 0), 1);
    waitIdle();
    getStat(s[0], stg, iss0, rd0, ex0, wr0);
    chk("R9 stage written", stg, 4);
    chk("R5 read after issue", rd0 - iss0, 1);
    chk("R2 load latency", ex0 - rd0, 1);
    chk("R5 write after exec", wr0 - ex0, 1);
    getStat(s[1], stg, iss, rd, ex, wr);
    chk("R6 mul reads after load write", rd, wr0 + 1);
    chk("R2 mul latency", ex - rd, 10);
    wr0 = wr;
    getStat(s[2], stg, iss, rd, ex, wr);
    chk("R6 add reads after mul write", rd, wr0 + 1);
    chk("R2 add latency", ex - rd, 2);
    wr0 = wr;
    getStat(s[3], stg, iss, rd, ex, wr);
    chk("R3 sub issues after adder frees", iss, wr0 + 1);
    chk("R2 sub latency", ex - rd, 2);

    // Scenario B: WAR hold on the multiply, WAW stall on the load
    expQ.push_back(4); expQ.push_back(1); expQ.push_back(0); expQ.push_back(3);
    issueInst(3'd4, 0, 2, 4, s[4], w);
    issueInst(3'd1, 6, 0, 8, s[5], w);
    chk("R8 adder Qj divider code", fuQjTab[9 +: 3], 5);
    chk("R8 adder Rj", fuRjTab[3], 0);
    chk("R8 adder Rk", fuRkTab[3], 1);
    chk("R8 adder Fk", fuFkTab[15 +: 5], 8);
    chk("R8 adder op", fuOpTab[9 +: 3], 1);
    chk("R8 regResult F6", regResultTab[18 +: 3], 4);
    issueInst(3'd3, 8, 10, 12, s[6], w);
    issueInst(3'd0, 0, 3, 0, s[7], w);
    chk("R4 load stall seen", (w > 0), 1);
    waitIdle();
    getStat(s[4], stg, iss, rdB, exB, wrB);
    chk("R2 div latency", exB - rdB, 40);
    getStat(s[7], stg, iss, rd, ex, wr);
    chk("R4 load issues after div write", iss, wrB + 1);
    wr0 = wr;
    getStat(s[5], stg, iss, rd, ex, wr);
    chk("R6 add reads after div write", rd, wrB + 1);
    chk("R10 simultaneous writes", wr, wr0);
    rdB = rd;
    getStat(s[6], stg, iss, rd, ex, wr);
    chk("R7 mul write after reader read", wr, rdB + 1);
    chk("R7 mul held after exec", wr - ex, 31);

    // Scenario C: both multipliers, then a third multiply stalls
    expQ.push_back(1); expQ.push_back(2); expQ.push_back(1);
    issueInst(3'd3, 20, 22, 24, s[8], w);
    issueInst(3'd3, 26, 22, 24, s[9], w);
    chk("R3 both multipliers busy", fuBusy[2:1], 3);
    issueInst(3'd3, 28, 22, 24, s[10], w);
    chk("R3 third mul stall seen", (w > 0), 1);
    chk("R2 third mul on unit 1", fuBusy[1], 1);
    waitIdle();
    getStat(s[8], stg, iss0, rd0, ex0, wr0);
    getStat(s[9], stg, iss, rd, ex, wr);
    chk("R2 second mul issues next cycle", iss, iss0 + 1);
    getStat(s[10], stg, iss, rd, ex, wr);
    chk("R3 third mul issues after unit frees", iss, wr0 + 1);

    repeat (3) @(negedge clk);
    chk("R10 all units free", fuBusy, 0);
    chk("R10 register results cleared", (regResultTab == '0), 1);
    chk("R10 expected writes drained", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule